// File: doc/BRIEF.md
# Four-Rail Power-Good Deglitch Monitor

This block turns per-rail over-voltage and under-voltage comparator flags into one active-high power-good signal per rail. Each rail has its own channel. The two flags of a channel are first passed through a two-flop synchronizer. A fault must then stay present for a minimum number of clock cycles before the channel's power-good drops, so short excursions are filtered out. Once the rail is back inside its window, power-good is held low for a long release delay before it rises again.

A global lockout input models a low supply on the monitor itself. While it is active, every output is forced low and all filter and delay counters are cleared. When lockout is released, each channel has to complete a full release delay before it asserts. Filter length and delay length are parameters given in clock cycles. The defaults match a 2.2 MHz clock with a filter of about 50 µs and a delay of about 10 ms.

Top module: `rail_pg_monitor`

## Requirements
- R1: A channel treats its over-voltage flag, its under-voltage flag, or both as a fault. A fault on one channel leaves the power-good outputs of the other channels unchanged.
- R2: A fault held on a channel's inputs for FILT_CYC or more consecutive cycles drives that channel's power-good low. The output falls exactly FILT_CYC+2 clock edges after the fault is first presented, two of those edges being the synchronizer.
- R3: A fault lasting fewer than FILT_CYC consecutive cycles is ignored, and the channel's power-good stays high.
- R4: After a dropped channel's inputs become fault-free, its power-good rises exactly HOLD_CYC+2 clock edges later, provided no fault is seen in between.
- R5: Any fault sampled during the release delay restarts the delay. Power-good then rises HOLD_CYC+2 edges after that fault clears, and not at the earlier time.
- R6: While lockout_i is high, every power-good output is low in the same cycle and all counters are cleared. After lockout_i falls, every channel needs HOLD_CYC fault-free edges before its power-good rises.
- R7: After reset all power-good outputs are low. With no faults present, they rise HOLD_CYC edges after rst_ni is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Monitor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lockout_i | input | 1 | Global lockout, active high, synchronous |
| ov_i | input | N_CH | Over-voltage flag for each channel |
| uv_i | input | N_CH | Under-voltage flag for each channel |
| pg_o | output | N_CH | Power-good for each channel, active high |

## Verification
The hardest case to reach is a fault that arrives partway through a running release delay. To get there, the stimulus first qualifies a fault, clears it, and waits about half the delay. It then injects a one-cycle glitch and confirms that power-good is still low when the first delay would have ended, and that it rises one full delay after the glitch clears. The bench shortens the filter and the delay through parameters, so these windows can be checked edge by edge.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_GOOD = 1'b1
  } pg_state_e;
endpackage

// File: rtl/pg_sync2.sv
module pg_sync2 #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pg_chan.sv
module pg_chan
  import pg_pkg::*;
#(
  parameter int FILT_CYC = 110,
  parameter int HOLD_CYC = 22000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  input  logic fault_i,
  output logic pg_o
);
  localparam int FW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);
  localparam int HW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
  localparam logic [FW-1:0] FLIM = FW'(FILT_CYC - 1);
  localparam logic [HW-1:0] HLIM = HW'(HOLD_CYC - 1);

  pg_state_e state_q;
  logic [FW-1:0] filt_cnt_q;
  logic [HW-1:0] hold_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_HOLD;
      filt_cnt_q <= '0;
      hold_cnt_q <= '0;
    end else if (lock_i) begin
      state_q    <= ST_HOLD;
      filt_cnt_q <= '0;
      hold_cnt_q <= '0;
    end else begin
      case (state_q)
        ST_GOOD: begin
          hold_cnt_q <= '0;
          if (!fault_i) begin
            filt_cnt_q <= '0;
          end else if (filt_cnt_q == FLIM) begin
            state_q    <= ST_HOLD;
            filt_cnt_q <= '0;
          end else begin
            filt_cnt_q <= filt_cnt_q + 1'b1;
          end
        end
        default: begin
          filt_cnt_q <= '0;
          if (fault_i) begin
            hold_cnt_q <= '0; // any fault restarts release delay
          end else if (hold_cnt_q == HLIM) begin
            state_q    <= ST_GOOD;
            hold_cnt_q <= '0;
          end else begin
            hold_cnt_q <= hold_cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign pg_o = (state_q == ST_GOOD);

  a_r2_fall_needs_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pg_o) |-> ($past(fault_i) || $past(lock_i)));

  a_r4_rise_needs_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pg_o) |-> (!$past(fault_i) && !$past(lock_i)));

  a_r5_fault_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && fault_i && !lock_i) |=> (hold_cnt_q == '0 && !pg_o));

  a_r6_lock_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> (!pg_o && filt_cnt_q == '0 && hold_cnt_q == '0));

  a_r3_filt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_cnt_q <= FLIM) && (hold_cnt_q <= HLIM));
endmodule

// File: rtl/rail_pg_monitor.sv
module rail_pg_monitor #(
  parameter int N_CH     = 4,
  parameter int FILT_CYC = 110,
  parameter int HOLD_CYC = 22000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lockout_i,
  input  logic [N_CH-1:0] ov_i,
  input  logic [N_CH-1:0] uv_i,
  output logic [N_CH-1:0] pg_o
);
  logic [N_CH-1:0] fault_s;
  logic [N_CH-1:0] pg_q;

  pg_sync2 #(.W(N_CH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ov_i | uv_i),
    .q_o   (fault_s)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    pg_chan #(.FILT_CYC(FILT_CYC), .HOLD_CYC(HOLD_CYC)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lock_i (lockout_i),
      .fault_i(fault_s[c]),
      .pg_o   (pg_q[c])
    );
  end

  // lockout masks outputs in the same cycle; registers clear on the next edge
  assign pg_o = pg_q & {N_CH{~lockout_i}};

  a_r1_single_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lockout_i && $past(!lockout_i)) |-> ($countones($past(pg_q) & ~pg_q) <= $countones($past(fault_s))));
endmodule

// File: tb/rail_pg_monitor_bench.sv
`timescale 1ns/1ps
module rail_pg_monitor_bench;
  localparam int N_CH = 4;
  localparam int FILT = 4;
  localparam int HOLD = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic lockout_i = 1'b0;
  logic [N_CH-1:0] ov_i = '0;
  logic [N_CH-1:0] uv_i = '0;
  logic [N_CH-1:0] pg_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  rail_pg_monitor #(.N_CH(N_CH), .FILT_CYC(FILT), .HOLD_CYC(HOLD)) u_rail_pg_monitor (
    .clk_i(clk_i), .rst_ni(rst_ni), .lockout_i(lockout_i),
    .ov_i(ov_i), .uv_i(uv_i), .pg_o(pg_o)
  );

  // {ch[1:0], ov, uv, len[6:0], drop}
  localparam logic [11:0] VEC [8] = '{
    {2'd0, 1'b1, 1'b0, 7'd4,  1'b1},
    {2'd1, 1'b0, 1'b1, 7'd4,  1'b1},
    {2'd2, 1'b1, 1'b1, 7'd6,  1'b1},
    {2'd3, 1'b0, 1'b1, 7'd3,  1'b0},
    {2'd0, 1'b1, 1'b0, 7'd1,  1'b0},
    {2'd1, 1'b1, 1'b0, 7'd3,  1'b0},
    {2'd2, 1'b0, 1'b1, 7'd5,  1'b1},
    {2'd3, 1'b1, 1'b0, 7'd10, 1'b1}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check(input string req, input logic [N_CH-1:0] act, input logic [N_CH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    @(negedge clk_i);
    check("R7 reset state", pg_o, 4'h0);
    rst_ni = 1'b1;
    step(HOLD - 1);
    check("R7 still low before delay", pg_o, 4'h0);
    step(1);
    check("R7 rise after delay", pg_o, 4'hF);

    // table: R1 R2 R3 R4
    for (int i = 0; i < 8; i++) begin
      logic [1:0] ch;
      logic [N_CH-1:0] exp;
      ch = VEC[i][11:10];
      ov_i[ch] = VEC[i][9];
      uv_i[ch] = VEC[i][8];
      step(int'(VEC[i][7:1]));
      ov_i = '0;
      uv_i = '0;
      step(3);
      exp = VEC[i][0] ? (4'hF & ~(4'b1 << ch)) : 4'hF;
      check(VEC[i][0] ? "R1 R2 qualified fault drops only its channel" : "R3 short fault ignored", pg_o, exp);
      step(HOLD + 4);
      check("R4 channel recovered", pg_o, 4'hF);
    end

    // R2 exact fall edge
    uv_i[1] = 1'b1;
    step(FILT + 1);
    check("R2 high one edge before fall", pg_o, 4'hF);
    step(1);
    check("R2 low at FILT+2", pg_o, 4'hD);
    // R4 exact rise edge
    uv_i[1] = 1'b0;
    step(HOLD + 1);
    check("R4 low one edge before rise", pg_o, 4'hD);
    step(1);
    check("R4 high at HOLD+2", pg_o, 4'hF);

    // R5 restart during release delay
    ov_i[2] = 1'b1;
    step(FILT + 2);
    ov_i[2] = 1'b0;
    step(HOLD / 2);
    ov_i[2] = 1'b1;
    step(1);
    ov_i[2] = 1'b0;
    step(HOLD / 2 + 2);
    check("R5 original delay end ignored", pg_o, 4'hB);
    step(HOLD + 1 - (HOLD / 2 + 2));
    check("R5 low one edge before restarted end", pg_o, 4'hB);
    step(1);
    check("R5 rise after restarted delay", pg_o, 4'hF);

    // R6 lockout
    lockout_i = 1'b1;
    #1;
    check("R6 lockout forces low same cycle", pg_o, 4'h0);
    step(3);
    lockout_i = 1'b0;
    #1;
    check("R6 stays low after release", pg_o, 4'h0);
    step(HOLD - 1);
    check("R6 low before full delay", pg_o, 4'h0);
    step(1);
    check("R6 rise after full delay", pg_o, 4'hF);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule